// File: doc/BRIEF.md
# Prescaled PWM Generator with Reload Modes

This block produces one pulse-width-modulated output from an eight-bit up-counter. The counter advances on ticks from a power-of-two prescaler. A small write port loads a control byte, a duty byte and a flag-clear command. The control byte sets the division ratio, run and clear, the reload width (6 or 8 bits), the counter arrangement (plain 8-bit or split 2+6-bit) and the output gate. A sticky overflow flag marks each reload event. The interrupt line is that flag gated by a separate enable input.

In the plain arrangement the output is high while the count is below the active duty value. In the split arrangement the low six count bits form a 64-count sub-period. The upper two duty bits then add one extra high count to that many of the four sub-periods, which gives quarter-step resolution. The duty byte first lands in a shadow register. It reaches the comparator only at a reload event, on a clear, or while the block is stopped, so a mid-period write never produces a partial pulse.

Top module: `pwm_prescaled`

## Requirements
- R1: Control bits 7:5 hold a value p. While running, the counter advances once every 2^p clock cycles, for p from 0 to 7.
- R2: Control bit 1 is run. While it is 0 the counter holds its value, the prescaler is held at zero and `pwmOut` is low.
- R3: Writing control bit 2 as 1 zeroes the counter and prescaler on the next clock edge. On that same edge the bit self-clears, so it reads back 1 for exactly one cycle.
- R4: Control bit 3 selects the reload width. With 0 the plain counter wraps after 63, giving a period of 64 counts. With 1 it wraps after 255, giving a period of 256 counts.
- R5: In plain mode (control bit 4 = 0) `pwmOut` is high while count < active duty. A duty of 0 keeps it low.
- R6: In split mode (control bit 4 = 1), let b = duty[5:0] and f = duty[7:6]. In sub-period s (count[7:6] = s), `pwmOut` is high while count[5:0] < b + (s < f ? 1 : 0). Over 256 counts there are 4b+f high counts.
- R7: Control bit 0 gates the waveform. With it at 0, `pwmOut` stays low.
- R8: `ovfFlag` sets on the edge where a tick finds the counter at its reload point. That point is count 255 when bit 3 = 1, or count[5:0] = 63 when bit 3 = 0. The flag stays set until a write to address 2 with data bit 0 = 1; a simultaneous set wins.
- R9: `irq` equals `ovfFlag` AND `irqEn`.
- R10: A duty write (address 1) takes effect at the next reload event, on a clear, or at once while stopped. A write during a period leaves that period unchanged.
- R11: After reset the control byte, flag, `pwmOut` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | 0 control, 1 duty, 2 flag clear |
| wrData | input | 8 | Write data |
| irqEn | input | 1 | Interrupt enable |
| pwmOut | output | 1 | Gated PWM waveform |
| irq | output | 1 | Interrupt request |
| ovfFlag | output | 1 | Sticky overflow flag |
| ctrlOut | output | 8 | Control byte readback |

## Verification
A wrong count, prescaler phase or active duty shows up as the wrong number of high cycles in a full PWM period. The error is visible within one period, which is 64 to 32768 clocks depending on reload width and division. A duty value copied too early shows up in the very period during which it was written. A counter that resets instead of holding across a stop shows up in the first window after the restart. A misplaced reload point moves the flag edge by at least one count interval. A clear bit that does not self-clear shows up on the readback one cycle after it was written.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W = 8;
  localparam int LOW_W = 6;
  localparam int PS_W  = 3;
  localparam int PRE_W = (1 << PS_W) - 1;
  localparam int HI_W  = CNT_W - LOW_W;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DUTY = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_NONE = 2'd3
  } addr_e;

  typedef struct packed {
    logic [PS_W-1:0] presc;
    logic            split;
    logic            reload8;
    logic            clr;
    logic            run;
    logic            outEn;
  } ctrl_t;

  typedef struct packed {
    logic tick;
    logic clear;
    logic loadIdle;
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             wrapEvt,
  output ctrl_t            ctrlQ,
  output logic [CNT_W-1:0] dutyShadow,
  output logic             ovfFlag,
  output strobe_t          strb
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic ctrlWr, dutyWr, flagClrWr, tickNow;

  assign ctrlWr    = wrEn && (wrAddr == ADDR_CTRL);
  assign dutyWr    = wrEn && (wrAddr == ADDR_DUTY);
  assign flagClrWr = wrEn && (wrAddr == ADDR_FLAG) && wrData[0];

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      preMask[i] = (i < int'(ctrlQ.presc));
    end
  end

  assign tickNow = ctrlQ.run && !ctrlQ.clr && ((preCnt & preMask) == preMask);

  always_comb begin
    strb.tick     = tickNow;
    strb.clear    = ctrlQ.clr;
    strb.loadIdle = !ctrlQ.run || ctrlQ.clr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (ctrlWr) begin
      ctrlQ <= ctrl_t'(wrData);
    end else if (ctrlQ.clr) begin
      ctrlQ.clr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyShadow <= '0;
    end else if (dutyWr) begin
      dutyShadow <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!ctrlQ.run || ctrlQ.clr) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (tickNow && wrapEvt) begin
      ovfFlag <= 1'b1;
    end else if (flagClrWr) begin
      ovfFlag <= 1'b0;
    end
  end

  // R3: clear request lasts a single cycle unless rewritten
  assert_clr_selfclear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.clr && !ctrlWr) |=> !ctrlQ.clr);

  // R1: with division above one, ticks never come back to back
  assert_presc_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (tickNow && (ctrlQ.presc != '0) && !ctrlWr) |=> !tickNow);

  // R8: the flag is sticky without a clear command
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClrWr) |=> ovfFlag);
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrlQ,
  input  strobe_t          strb,
  input  logic [CNT_W-1:0] dutyShadow,
  output logic             wrapEvt,
  output logic             pwmOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dutyAct;
  logic             lowFull, extra, plainHit, splitHit, hit;
  logic [LOW_W:0]   thresh;

  assign lowFull = &cnt[LOW_W-1:0];
  assign wrapEvt = ctrlQ.reload8 ? (&cnt) : lowFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clear) begin
      cnt <= '0;
    end else if (strb.tick) begin
      if (!ctrlQ.split && !ctrlQ.reload8 && lowFull) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dutyAct <= '0;
    end else if (strb.loadIdle || (strb.tick && wrapEvt)) begin
      dutyAct <= dutyShadow;
    end
  end

  always_comb begin
    extra    = cnt[CNT_W-1:LOW_W] < dutyAct[CNT_W-1:LOW_W];
    thresh   = {1'b0, dutyAct[LOW_W-1:0]} + {{LOW_W{1'b0}}, extra};
    splitHit = {1'b0, cnt[LOW_W-1:0]} < thresh;
    plainHit = cnt < dutyAct;
    hit      = ctrlQ.split ? splitHit : plainHit;
  end

  assign pwmOut = ctrlQ.run && ctrlQ.outEn && hit;

  // R2: without a tick or clear the count does not move
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.clear) |=> $stable(cnt));

  // R3: a clear strobe leaves the counter at zero
  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (cnt == '0));

  // R10: active duty only moves on a load opportunity
  assert_duty_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadIdle && !(strb.tick && wrapEvt)) |=> $stable(dutyAct));
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             irqEn,
  output logic             pwmOut,
  output logic             irq,
  output logic             ovfFlag,
  output logic [CNT_W-1:0] ctrlOut
);
  ctrl_t            ctrlQ;
  strobe_t          strb;
  logic [CNT_W-1:0] dutyShadow;
  logic             wrapEvt;

  pwm_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrapEvt(wrapEvt), .ctrlQ(ctrlQ), .dutyShadow(dutyShadow),
    .ovfFlag(ovfFlag), .strb(strb)
  );

  pwm_datapath uData (
    .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .strb(strb),
    .dutyShadow(dutyShadow), .wrapEvt(wrapEvt), .pwmOut(pwmOut)
  );

  assign irq     = ovfFlag && irqEn;
  assign ctrlOut = ctrlQ;
endmodule

// File: tb/tb_pwm_prescaled.sv
`timescale 1ns/1ps
module tb_pwm_prescaled;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd3;
  logic [7:0] wrData = 8'd0;
  logic irqEn = 1'b1;
  logic pwmOut, irq, ovfFlag;
  logic [7:0] ctrlOut;

  int checks = 0;
  int fails = 0;

  typedef struct { int len; int expHigh; string tag; } win_t;
  win_t q[$];
  win_t cur;
  bit   active = 1'b0;
  int   seen = 0;
  int   highs = 0;

  localparam logic [7:0] OE = 8'h01, RUN = 8'h02, CLR = 8'h04, RL8 = 8'h08, SPL = 8'h10;

  always #2.5 clk = ~clk;

  pwm_prescaled dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irqEn(irqEn), .pwmOut(pwmOut), .irq(irq), .ovfFlag(ovfFlag), .ctrlOut(ctrlOut)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts high samples per queued window, compares at window end
  always @(negedge clk) begin
    if (!active && q.size() > 0) begin
      cur = q.pop_front();
      active = 1'b1;
      seen = 0;
      highs = 0;
    end
    if (active) begin
      seen++;
      highs += int'(pwmOut);
      if (seen == cur.len) begin
        chk(cur.tag, highs, cur.expHigh);
        active = 1'b0;
      end
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0; wrAddr = 2'd3;
  endtask

  task automatic expectWin(int len, int expHigh, string tag);
    win_t w;
    w.len = len; w.expHigh = expHigh; w.tag = tag;
    q.push_back(w);
  endtask

  task automatic waitIdle();
    wait (q.size() == 0 && !active);
  endtask

  task automatic start(logic [7:0] ctrl, logic [7:0] duty);
    wr(2'd1, duty);
    wr(2'd0, (ctrl & ~RUN) | CLR);
    wr(2'd2, 8'h01);
    wr(2'd0, ctrl | RUN);
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 ctrl", ctrlOut, 0);
    chk("R11 pwm", pwmOut, 0);
    chk("R11 flag", ovfFlag, 0);
    chk("R11 irq", irq, 0);

    // R5 R4 plain 8-bit, duty 100
    start(OE | RL8, 8'd100);
    expectWin(256, 100, "R5 plain duty100");
    waitIdle();
    chk("R8 flag not early", ovfFlag, 0);
    @(negedge clk);
    chk("R8 flag at reload", ovfFlag, 1);
    chk("R9 irq follows flag", irq, 1);
    repeat (5) @(negedge clk);
    chk("R8 flag sticky", ovfFlag, 1);
    irqEn = 1'b0;
    #1 chk("R9 irq gated", irq, 0);
    irqEn = 1'b1;
    wr(2'd2, 8'h01);
    @(negedge clk);
    chk("R8 flag cleared", ovfFlag, 0);

    start(OE | RL8, 8'd0);
    expectWin(256, 0, "R5 duty zero");
    waitIdle();
    start(OE | RL8, 8'd255);
    expectWin(256, 255, "R5 duty255");
    waitIdle();

    // R4 6-bit reload
    start(OE, 8'd40);
    expectWin(64, 40, "R4 reload6 duty40");
    waitIdle();
    start(OE, 8'd200);
    expectWin(64, 64, "R4 reload6 duty200");
    waitIdle();

    // R1 prescaler
    start(OE | (8'd2 << 5), 8'd10);
    expectWin(256, 40, "R1 div4");
    waitIdle();
    start(OE | (8'd7 << 5), 8'd5);
    expectWin(8192, 640, "R1 div128");
    waitIdle();

    // R6 split mode
    start(OE | RL8 | SPL, 8'h41);
    expectWin(256, 5, "R6 split 0x41");
    waitIdle();
    start(OE | RL8 | SPL, 8'hFF);
    expectWin(256, 255, "R6 split 0xFF");
    waitIdle();
    start(OE | RL8 | SPL, 8'h8A);
    expectWin(256, 42, "R6 split 0x8A");
    waitIdle();
    start(OE | SPL, 8'h8A);
    expectWin(64, 11, "R6 split reload6 first sub-period");
    waitIdle();
    @(negedge clk);
    chk("R8 split reload6 flag at 64", ovfFlag, 1);

    // R7 output gate
    start(RL8, 8'd100);
    expectWin(256, 0, "R7 outEn off");
    waitIdle();

    // R10 double buffering
    start(OE | RL8, 8'd100);
    expectWin(256, 100, "R10 period unchanged");
    repeat (50) @(negedge clk);
    wr(2'd1, 8'd10);
    expectWin(256, 10, "R10 new duty next period");
    waitIdle();

    // R3 clear while running
    wr(2'd0, OE | RL8 | RUN | CLR);
    @(negedge clk);
    chk("R3 clr reads 1", int'(ctrlOut[2]), 1);
    @(posedge clk);
    #1 expectWin(256, 10, "R3 counter restarted");
    @(negedge clk);
    chk("R3 clr self-cleared", int'(ctrlOut[2]), 0);
    waitIdle();

    // R2 stop holds counter, output low
    start(OE | RL8, 8'd100);
    expectWin(30, 30, "R2 before stop");
    waitIdle();
    wr(2'd0, OE | RL8);
    expectWin(20, 0, "R2 stopped output low");
    waitIdle();
    wr(2'd0, OE | RL8 | RUN);
    expectWin(100, 69, "R2 count held across stop");
    waitIdle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule